// File: doc/BRIEF.md
# System Control Configuration Register

This block is one 32-bit configuration word held in a coprocessor-style register space. An access presents an opcode pair and two register-number fields. The block answers only when all four fields name it. For privileged accesses it returns the word combinationally on a read, and it updates the writable bits on the next clock edge on a write. A user-mode access that names the register returns no data and changes nothing. It raises an undefined-instruction indication instead.

The bits of the word have three kinds of behaviour. Some are writable. Some are held at zero and ignore writes. Some are held at one and ignore writes. At reset, three configuration straps set the vector-location bit, the endianness bit, the unaligned-access bit and the exception-endianness bit. The whole word drives the output bus `ctl_word`, and downstream logic reads its control bits from that bus.

Each access is classified into one of four kinds: IDLE (no valid access, or the fields do not match), READ (privileged read), WRITE (privileged write) and TRAP (user-mode access). There is no stored sequencing. Every cycle makes an independent transition from the current inputs into one of these kinds. The only state is the word itself, which moves from its reset value to a new value on each WRITE.

Top module: `sysctl_cfg_reg`

## Requirements
- R1: An access selects the register only when `acc_valid` is 1, `acc_op1`=0, `acc_crn`=1, `acc_crm`=0 and `acc_op2`=0. Any other access gives `acc_rdata`=0 and `acc_undef`=0, and it leaves `ctl_word` unchanged.
- R2: A selected access with `acc_priv`=0 sets `acc_undef`=1 in the same cycle. It returns `acc_rdata`=0 and leaves `ctl_word` unchanged, whether it is a read or a write.
- R3: Bits 31:30, 27:26, 20:19, 17 and 10 (mask 0xCC1A0400) always read 0. Writes do not change them.
- R4: Bits 18, 16, 6:4 and 3 (mask 0x00050078) always read 1, whatever value is written.
- R5: A selected privileged write (`acc_write`=1) replaces the bits in mask 0x33E0FB87 with `acc_wdata` at the next rising clock edge. A selected privileged read (`acc_write`=0) returns the current word on `acc_rdata` in the same cycle.
- R6: While `rst_n`=0 at a clock edge, the word loads its reset value. Bit 13 equals `strap_hivec` and bit 22 equals `strap_unalign`. Bit 7 is `strap_bigend` AND NOT `strap_unalign`. Bit 25 is `strap_bigend` AND `strap_unalign`. The other writable bits are 0. The resulting values with high-vectors off are 0x00050078 (no straps), 0x000500F8 (big-endian), 0x00450078 (unaligned) and 0x02450078 (both). With high-vectors on, each value has 0x2000 added.
- R7: `ctl_word` always equals the current register contents, and it changes only at a clock edge.
- R8: Writing back the value just read leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hivec | input | 1 | Reset value of the high-vectors bit (13) |
| strap_bigend | input | 1 | Big-endian reset strap |
| strap_unalign | input | 1 | Unaligned-access reset strap |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (0 unless a privileged read selects the block) |
| acc_undef | output | 1 | Undefined-instruction indication for user access |
| ctl_word | output | 32 | Current control word |

## Verification
Assertions check several properties on every cycle. The fixed-zero and fixed-one bits must hold their values, and the bits outside the write mask must never move. Cycles without a write must leave the word stable, and a trap must be followed by an unchanged word. Read data or a trap may appear only for the decoded register address. Other behaviour needs the bench's scenarios and its reference model. That covers the exact strap-dependent reset values, write data landing in the correct bits on the following edge, and the read-modify-write round trip.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    localparam int DATA_W = 32;
    localparam int OP1_W  = 3;
    localparam int CRN_W  = 4;
    localparam int CRM_W  = 4;
    localparam int OP2_W  = 3;

    // Bits software may change
    localparam logic [DATA_W-1:0] WR_MASK   = 32'h33E0_FB87;
    // Bits that are tied to one
    localparam logic [DATA_W-1:0] ONE_MASK  = 32'h0005_0078;
    // Bits that are tied to zero
    localparam logic [DATA_W-1:0] ZERO_MASK = ~(WR_MASK | ONE_MASK);

    localparam int BIT_ENDIAN = 7;
    localparam int BIT_HIVEC  = 13;
    localparam int BIT_UNAL   = 22;
    localparam int BIT_EXCEND = 25;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_TRAP
    } acc_kind_e;
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
    import cfgreg_pkg::*;
#(
    parameter logic [OP1_W-1:0] SEL_OP1 = '0,
    parameter logic [CRN_W-1:0] SEL_CRN = CRN_W'(1),
    parameter logic [CRM_W-1:0] SEL_CRM = '0,
    parameter logic [OP2_W-1:0] SEL_OP2 = '0
) (
    input  logic             valid,
    input  logic             write,
    input  logic             priv,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output acc_kind_e        kind
);
    logic match;

    assign match = (op1 == SEL_OP1) && (crn == SEL_CRN) &&
                   (crm == SEL_CRM) && (op2 == SEL_OP2);

    always_comb begin
        if (!valid || !match)
            kind = ACC_IDLE;
        else if (!priv)
            kind = ACC_TRAP;
        else if (write)
            kind = ACC_WRITE;
        else
            kind = ACC_READ;
    end
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hivec,
    input  logic              strap_bigend,
    input  logic              strap_unalign,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] rst_val;

    always_comb begin
        rst_val             = ONE_MASK;
        rst_val[BIT_HIVEC]  = strap_hivec;
        rst_val[BIT_UNAL]   = strap_unalign;
        rst_val[BIT_ENDIAN] = strap_bigend & ~strap_unalign;
        rst_val[BIT_EXCEND] = strap_bigend & strap_unalign;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= rst_val;
        else if (wr_en)
            q <= (q & ~WR_MASK) | (wdata & WR_MASK);
    end

    // R3: bits outside the write mask never move once out of reset
    p_fixed_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(q & ~WR_MASK))
        else $error("fixed bits changed");

    // R3 / R4: tied bits hold their values
    p_tied_values_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ZERO_MASK) == '0) && ((q & ONE_MASK) == ONE_MASK))
        else $error("tied bits wrong");

    // R2 / R7: no write strobe, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q))
        else $error("word changed without write");
endmodule

// File: rtl/sysctl_cfg_reg.sv
module sysctl_cfg_reg
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hivec,
    input  logic              strap_bigend,
    input  logic              strap_unalign,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [OP1_W-1:0]  acc_op1,
    input  logic [CRN_W-1:0]  acc_crn,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OP2_W-1:0]  acc_op2,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    output logic [DATA_W-1:0] ctl_word
);
    acc_kind_e         kind;
    logic              wr_en;
    logic [DATA_W-1:0] word_q;

    cfgreg_decode i_decode (
        .valid (acc_valid),
        .write (acc_write),
        .priv  (acc_priv),
        .op1   (acc_op1),
        .crn   (acc_crn),
        .crm   (acc_crm),
        .op2   (acc_op2),
        .kind  (kind)
    );

    cfgreg_store i_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_hivec   (strap_hivec),
        .strap_bigend  (strap_bigend),
        .strap_unalign (strap_unalign),
        .wr_en         (wr_en),
        .wdata         (acc_wdata),
        .q             (word_q)
    );

    always_comb begin
        acc_rdata = '0;
        acc_undef = 1'b0;
        wr_en     = 1'b0;
        unique case (kind)
            ACC_IDLE:  ;
            ACC_READ:  acc_rdata = word_q;
            ACC_WRITE: wr_en     = 1'b1;
            ACC_TRAP:  acc_undef = 1'b1;
        endcase
    end

    assign ctl_word = word_q;

    // R1: data or trap only for the decoded address
    p_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_undef || (acc_rdata != '0)) |->
            (acc_valid && acc_op1 == '0 && acc_crn == CRN_W'(1) &&
             acc_crm == '0 && acc_op2 == '0))
        else $error("response outside decoded address");

    // R2: a trapped access leaves the word alone
    p_trap_nochange_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_undef |=> $stable(ctl_word))
        else $error("trap changed word");

    // R2: user mode never gets data
    p_trap_nodata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv) |-> (acc_rdata == '0))
        else $error("user read returned data");
endmodule

// File: tb/test_sysctl_cfg_reg.sv
module test_sysctl_cfg_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] WM = 32'h33E0_FB87;
    localparam logic [31:0] OM = 32'h0005_0078;
    localparam logic [31:0] ZM = 32'hCC1A_0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_hivec = 1'b0, strap_bigend = 1'b0, strap_unalign = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [2:0] acc_op1 = '0;
    logic [3:0] acc_crn = '0;
    logic [3:0] acc_crm = '0;
    logic [2:0] acc_op2 = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic acc_undef;
    logic [31:0] ctl_word;

    int vectors = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    logic [31:0] model = '0;
    logic [31:0] rd_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cfg_reg i_sysctl_cfg_reg (
        .clk(clk), .rst_n(rst_n),
        .strap_hivec(strap_hivec), .strap_bigend(strap_bigend),
        .strap_unalign(strap_unalign),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_priv(acc_priv),
        .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
        .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_undef(acc_undef), .ctl_word(ctl_word)
    );

    function automatic logic [31:0] reset_of(logic h, logic b, logic u);
        logic [31:0] v;
        case ({u, b})
            2'b00: v = 32'h0005_0078;
            2'b01: v = 32'h0005_00F8;
            2'b10: v = 32'h0045_0078;
            default: v = 32'h0245_0078;
        endcase
        return h ? (v + 32'h2000) : v;
    endfunction

    function automatic bit selected();
        return acc_valid && acc_op1 == 3'd0 && acc_crn == 4'd1 &&
               acc_crm == 4'd0 && acc_op2 == 3'd0;
    endfunction

    // Reference model, R5 / R6
    always @(posedge clk) begin
        if (!rst_n)
            model <= reset_of(strap_hivec, strap_bigend, strap_unalign);
        else if (selected() && acc_priv && acc_write)
            model <= (model & ~WM) | (acc_wdata & WM);
        started <= 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // R7: output bus compared every clock
    always @(negedge clk) begin
        if (started && !done) check("R7 ctl_word", ctl_word, model);
    end

    task automatic access(input logic v, input logic w, input logic p,
                          input logic [2:0] o1, input logic [3:0] cn,
                          input logic [3:0] cm, input logic [2:0] o2,
                          input logic [31:0] wd, input string req);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_priv = p;
        acc_op1 = o1; acc_crn = cn; acc_crm = cm; acc_op2 = o2;
        acc_wdata = wd;
        #1;
        check({req, " undef"}, {31'd0, acc_undef}, {31'd0, selected() && !p});
        check({req, " rdata"}, acc_rdata, (selected() && p && !w) ? model : 32'h0);
        rd_hold = acc_rdata;
    endtask

    task automatic rd(input string req);
        access(1, 0, 1, 0, 1, 0, 0, 32'h0, req);
    endtask

    task automatic wr(input logic [31:0] d, input string req);
        access(1, 1, 1, 0, 1, 0, 0, d, req);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic do_reset(input logic h, input logic b, input logic u,
                            input logic [31:0] exp, input string req);
        @(negedge clk);
        acc_valid = 0;
        strap_hivec = h; strap_bigend = b; strap_unalign = u;
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(req, ctl_word, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset values for each strap pattern
        do_reset(0, 0, 0, 32'h0005_0078, "R6 straps none");
        rd("R5 read after reset");
        check("R5 read value", rd_hold, 32'h0005_0078);

        // R5 / R3 / R4: write all ones
        wr(32'hFFFF_FFFF, "R5 write ones");
        rd("R5 read ones");
        check("R5 all-ones result", rd_hold, 32'h33E5_FBFF);
        check("R3 zero bits", rd_hold & ZM, 32'h0);
        check("R4 one bits", rd_hold & OM, OM);

        // R4: write zeros, tied-one bits remain
        wr(32'h0000_0000, "R4 write zeros");
        rd("R4 read zeros");
        check("R4 after zero write", rd_hold, 32'h0005_0078);

        // R2: user mode write and read trap, no change
        access(1, 1, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, "R2 user write");
        access(1, 0, 0, 0, 1, 0, 0, 32'h0, "R2 user read");
        idle();
        check("R2 unchanged", ctl_word, 32'h0005_0078);

        // R1: non-matching fields, privileged and user
        access(1, 1, 1, 1, 1, 0, 0, 32'hFFFF_FFFF, "R1 op1 mismatch");
        access(1, 1, 1, 0, 2, 0, 0, 32'hFFFF_FFFF, "R1 crn mismatch");
        access(1, 1, 1, 0, 1, 1, 0, 32'hFFFF_FFFF, "R1 crm mismatch");
        access(1, 1, 1, 0, 1, 0, 1, 32'hFFFF_FFFF, "R1 op2 mismatch");
        access(1, 0, 0, 0, 1, 0, 4, 32'h0, "R1 user mismatch");
        access(0, 1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, "R1 not valid");
        idle();
        check("R1 unchanged", ctl_word, 32'h0005_0078);

        // R8: read-modify-write round trip
        wr(32'h0280_1905, "R8 seed");
        rd("R8 read");
        wr(rd_hold, "R8 write back");
        rd("R8 reread");
        check("R8 round trip", rd_hold, 32'h0285_197D);

        // R6: other strap combinations
        do_reset(1, 0, 0, 32'h0005_2078, "R6 hivec");
        do_reset(0, 1, 0, 32'h0005_00F8, "R6 bigend");
        do_reset(0, 0, 1, 32'h0045_0078, "R6 unalign");
        do_reset(1, 0, 1, 32'h0045_2078, "R6 unalign hivec");
        do_reset(0, 1, 1, 32'h0245_0078, "R6 both");
        do_reset(1, 1, 1, 32'h0245_2078, "R6 all");

        // R5 / R2 / R1: mixed random traffic against the model
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            access(1, r[0], r[1], {2'b0, r[2] & r[3]}, 4'd1, 4'd0, 3'd0,
                   $urandom, "R5 random");
        end
        idle();
        idle();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule